// File: doc/BRIEF.md
# Ring Insertion Scrub Controller

This block decides when a station port joins or leaves a ring network. It sits beside a physical connection manager. When the port is asked to join, it first runs a timed scrub phase. During that phase the transmit path sends only Idle symbols, so old frames circulating on the ring are flushed out. After the scrub the port counts as inserted. Leaving the ring works the same way: a timed scrub phase runs first, and then the port is removed. A new scrub can also be requested while the port is inserted, or while an insertion scrub is still running.

The scrub length is a 16-bit value, counted in ticks of a byte-clock strobe. A port that is single-attach, or one in maintenance mode, does not start insertion until the connection manager says the link is active. The block drives four outputs: a 2-bit state code, a joined flag, a select for the Idle-substitution multiplexer and a bypass-control line. It also gives a one-cycle pulse after every change of state.

Top module: `ring_insert_ctl`

## Requirements
- R1: After reset the state code is 0 (removed). joined, idleSel, bypassCtl and stateEvent are all low.
- R2: In state 0, a normal station that sees joinReq high moves on the next clock edge to state 1 (insertion scrub). In state 1, idleSel and bypassCtl are high.
- R3: A scrub phase lasts until more than tScrub tick strobes have been counted since the scrub timer was loaded. After exactly tScrub ticks the state has not changed. In the clock cycle after tick number tScrub+1, the state leaves the scrub.
- R4: State 1 moves to state 3 (inserted) only when the scrub has expired, joinReq is high and scrubReq is low. If scrubReq is high in state 1, the scrub timer reloads and the state stays 1.
- R5: In state 3, joined is high, bypassCtl is high and idleSel is low.
- R6: If joinReq is low in state 3 or in state 1, the next state is 2 (removal scrub) and the scrub timer reloads. This takes priority over an expiry that falls in the same cycle.
- R7: State 2 goes to state 0 when its scrub expires. joinReq and scrubReq have no effect while in state 2.
- R8: If singleAttach or maintMode is high, state 0 stays 0 and bypassCtl stays low while pcmActive is low. Once pcmActive is high and joinReq is high, the next state is 1.
- R9: In state 3, if joinReq and scrubReq are both high, the next state is 1 and the scrub timer reloads.
- R10: stateEvent is high for exactly the one cycle after each clock edge that changed the state code. It is low at all other times.
- R11: tScrub is read only when the scrub timer loads. Changing tScrub during a scrub does not change how long that scrub lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| joinReq | input | 1 | Request to be (or stay) inserted in the ring |
| scrubReq | input | 1 | Request for a new insertion scrub |
| singleAttach | input | 1 | Station is single-attach class |
| maintMode | input | 1 | Maintenance mode |
| pcmActive | input | 1 | Connection manager has reached its active state |
| tScrub | input | 16 | Scrub length in ticks (the scrub ends after tScrub+1 ticks) |
| tick | input | 1 | Timer tick strobe |
| stateCode | output | 2 | 0 removed, 1 insert scrub, 2 remove scrub, 3 inserted |
| joined | output | 1 | Station is inserted |
| idleSel | output | 1 | Select Idle symbols on the transmit path |
| bypassCtl | output | 1 | Bypass-control line, high when not removed |
| stateEvent | output | 1 | One-cycle pulse after each state change |

## Verification
Two things can land in the same cycle: the scrub timer expiring during an insertion scrub, and joinReq dropping or scrubReq rising. The bench lines these up on purpose. It times the tick strobes so that the expiry becomes visible in exactly the cycle where joinReq falls, or where scrubReq is held high. It then checks that the removal scrub wins, or that the timer restarts, instead of the port being inserted. After that, the fresh timer must need the full tScrub+1 ticks again before the state moves on.

// File: rtl/ris_pkg.sv
package ris_pkg;

  typedef enum logic [1:0] {
    ST_REMOVED   = 2'd0,
    ST_INS_SCRUB = 2'd1,
    ST_REM_SCRUB = 2'd2,
    ST_INSERTED  = 2'd3
  } risState_e;

  // Strobes from the control FSM to the scrub timer
  typedef struct packed {
    logic load;  // load the timer with the complemented scrub time
    logic run;   // allow counting on tick
  } timerCtl_t;

endpackage

// File: rtl/ris_timer.sv
module ris_timer
  import ris_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  timerCtl_t     ctl,
  input  logic [TW-1:0] tScrub,
  input  logic          tick,
  output logic          expired
);

  localparam int CW = TW + 1;

  logic [CW-1:0] count;

  // Loaded with the ones' complement of tScrub. The carry into the top bit
  // then appears after tScrub+1 ticks, which is when elapsed time exceeds tScrub.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctl.load) begin
      count <= {1'b0, ~tScrub};
    end else if (ctl.run && tick && !count[CW-1]) begin
      count <= count + 1'b1;
    end
  end

  assign expired = count[CW-1];

endmodule

// File: rtl/ris_ctrl.sv
module ris_ctrl
  import ris_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      joinReq,
  input  logic      scrubReq,
  input  logic      singleAttach,
  input  logic      maintMode,
  input  logic      pcmActive,
  input  logic      expired,
  output timerCtl_t ctl,
  output risState_e state,
  output logic      stateEvent
);

  risState_e nxt;
  logic      holdForActive;

  assign holdForActive = (singleAttach || maintMode) && !pcmActive;

  always_comb begin
    nxt      = state;
    ctl.load = 1'b0;
    ctl.run  = (state == ST_INS_SCRUB) || (state == ST_REM_SCRUB);
    unique case (state)
      ST_REMOVED: begin
        if (joinReq && !holdForActive) begin
          nxt      = ST_INS_SCRUB;
          ctl.load = 1'b1;
        end
      end
      ST_INS_SCRUB: begin
        if (!joinReq) begin
          nxt      = ST_REM_SCRUB;
          ctl.load = 1'b1;
        end else if (scrubReq) begin
          ctl.load = 1'b1;
        end else if (expired) begin
          nxt = ST_INSERTED;
        end
      end
      ST_INSERTED: begin
        if (!joinReq) begin
          nxt      = ST_REM_SCRUB;
          ctl.load = 1'b1;
        end else if (scrubReq) begin
          nxt      = ST_INS_SCRUB;
          ctl.load = 1'b1;
        end
      end
      ST_REM_SCRUB: begin
        if (expired) nxt = ST_REMOVED;
      end
      default: nxt = ST_REMOVED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_REMOVED;
      stateEvent <= 1'b0;
    end else begin
      state      <= nxt;
      stateEvent <= (nxt != state);
    end
  end

endmodule

// File: rtl/ring_insert_ctl.sv
module ring_insert_ctl
  import ris_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          joinReq,
  input  logic          scrubReq,
  input  logic          singleAttach,
  input  logic          maintMode,
  input  logic          pcmActive,
  input  logic [TW-1:0] tScrub,
  input  logic          tick,
  output logic [1:0]    stateCode,
  output logic          joined,
  output logic          idleSel,
  output logic          bypassCtl,
  output logic          stateEvent
);

  timerCtl_t ctl;
  risState_e state;
  logic      expired;

  ris_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .joinReq     (joinReq),
    .scrubReq    (scrubReq),
    .singleAttach(singleAttach),
    .maintMode   (maintMode),
    .pcmActive   (pcmActive),
    .expired     (expired),
    .ctl         (ctl),
    .state       (state),
    .stateEvent  (stateEvent)
  );

  ris_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .tScrub (tScrub),
    .tick   (tick),
    .expired(expired)
  );

  assign stateCode = state;
  assign joined    = (state == ST_INSERTED);
  assign idleSel   = (state == ST_INS_SCRUB) || (state == ST_REM_SCRUB);
  assign bypassCtl = (state != ST_REMOVED);

endmodule

// File: rtl/ris_chk.sv
module ris_chk (
  input logic       clk,
  input logic       rstN,
  input logic       joinReq,
  input logic       singleAttach,
  input logic       maintMode,
  input logic       pcmActive,
  input logic [1:0] stateCode,
  input logic       joined,
  input logic       idleSel,
  input logic       bypassCtl,
  input logic       stateEvent
);

  // R10
  event_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != $past(stateCode)) |-> stateEvent);

  // R5
  inserted_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    joined |-> (bypassCtl && !idleSel));

  // R6
  leave_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 2'd3 && !joinReq) |=> (stateCode == 2'd2));

  // R7
  remove_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 2'd2) |=> (stateCode == 2'd2 || stateCode == 2'd0));

  // R8
  hold_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 2'd0 && (singleAttach || maintMode) && !pcmActive)
      |=> (stateCode == 2'd0 && !bypassCtl));

endmodule

bind ring_insert_ctl ris_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .joinReq     (joinReq),
  .singleAttach(singleAttach),
  .maintMode   (maintMode),
  .pcmActive   (pcmActive),
  .stateCode   (stateCode),
  .joined      (joined),
  .idleSel     (idleSel),
  .bypassCtl   (bypassCtl),
  .stateEvent  (stateEvent)
);

// File: tb/test_ring_insert_ctl.sv
module test_ring_insert_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        joinReq = 1'b0;
  logic        scrubReq = 1'b0;
  logic        singleAttach = 1'b0;
  logic        maintMode = 1'b0;
  logic        pcmActive = 1'b0;
  logic [15:0] tScrub = 16'd2;
  logic        tick = 1'b0;
  logic [1:0]  stateCode;
  logic        joined, idleSel, bypassCtl, stateEvent;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ring_insert_ctl i_ring_insert_ctl (
    .clk(clk), .rstN(rstN), .joinReq(joinReq), .scrubReq(scrubReq),
    .singleAttach(singleAttach), .maintMode(maintMode), .pcmActive(pcmActive),
    .tScrub(tScrub), .tick(tick), .stateCode(stateCode), .joined(joined),
    .idleSel(idleSel), .bypassCtl(bypassCtl), .stateEvent(stateEvent)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one tick strobe; on return the counting edge has passed
  task automatic pulseTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic t_reset();
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    chk("R1", "state", stateCode, 0);
    chk("R1", "joined", joined, 0);
    chk("R1", "idleSel", idleSel, 0);
    chk("R1", "bypassCtl", bypassCtl, 0);
    chk("R1", "stateEvent", stateEvent, 0);
  endtask

  task automatic t_insert();
    tScrub = 16'd2;
    joinReq = 1'b1;
    cyc(1);
    chk("R2", "state", stateCode, 1);
    chk("R2", "idleSel", idleSel, 1);
    chk("R2", "bypassCtl", bypassCtl, 1);
    chk("R10", "event on change", stateEvent, 1);
    cyc(1);
    chk("R10", "event cleared", stateEvent, 0);
    pulseTick(); pulseTick();
    cyc(3);
    chk("R3", "still scrubbing after T ticks", stateCode, 1);
    pulseTick();
    chk("R3", "expiry cycle", stateCode, 1);
    cyc(1);
    chk("R3", "inserted after T+1", stateCode, 3);
    chk("R5", "joined", joined, 1);
    chk("R5", "idleSel", idleSel, 0);
    chk("R5", "bypassCtl", bypassCtl, 1);
  endtask

  task automatic t_remove();
    tScrub = 16'd1;
    joinReq = 1'b0;
    cyc(1);
    chk("R6", "remove scrub", stateCode, 2);
    joinReq = 1'b1;
    scrubReq = 1'b1;
    cyc(2);
    chk("R7", "join ignored", stateCode, 2);
    scrubReq = 1'b0;
    pulseTick();
    chk("R7", "one tick", stateCode, 2);
    pulseTick();
    chk("R7", "expiry cycle", stateCode, 2);
    cyc(1);
    chk("R7", "removed", stateCode, 0);
    cyc(1);
    chk("R2", "rejoin", stateCode, 1);
  endtask

  task automatic t_rescrub();
    // T=1, fresh timer in state 1
    pulseTick();
    @(negedge clk) begin tick = 1'b1; end
    @(negedge clk) begin tick = 1'b0; scrubReq = 1'b1; end
    cyc(2);
    chk("R4", "scrubReq blocks insert", stateCode, 1);
    scrubReq = 1'b0;
    pulseTick();
    cyc(2);
    chk("R4", "timer reloaded", stateCode, 1);
    pulseTick();
    cyc(1);
    chk("R4", "inserted", stateCode, 3);
  endtask

  task automatic t_scrubInserted();
    @(negedge clk) scrubReq = 1'b1;
    @(negedge clk) scrubReq = 1'b0;
    chk("R9", "rescrub", stateCode, 1);
    pulseTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) begin tick = 1'b0; joinReq = 1'b0; end
    cyc(1);
    chk("R6", "drop wins over expiry", stateCode, 2);
    pulseTick();
    cyc(1);
    chk("R6", "fresh removal timer", stateCode, 2);
    pulseTick();
    cyc(1);
    chk("R7", "removed", stateCode, 0);
  endtask

  task automatic t_sampleT();
    tScrub = 16'd1;
    joinReq = 1'b1;
    cyc(1);
    chk("R11", "scrub", stateCode, 1);
    tScrub = 16'd50;
    pulseTick(); pulseTick();
    cyc(1);
    chk("R11", "old length used", stateCode, 3);
    tScrub = 16'd1;
    joinReq = 1'b0;
    pulseTick(); pulseTick();
    cyc(1);
    chk("R7", "back to removed", stateCode, 0);
  endtask

  task automatic t_singleAttach();
    singleAttach = 1'b1;
    joinReq = 1'b1;
    cyc(5);
    chk("R8", "single-attach waits", stateCode, 0);
    chk("R8", "no bypass", bypassCtl, 0);
    pcmActive = 1'b1;
    cyc(1);
    chk("R8", "starts on active", stateCode, 1);
    joinReq = 1'b0;
    pcmActive = 1'b0;
    singleAttach = 1'b0;
    pulseTick(); pulseTick();
    cyc(1);
    chk("R8", "removed again", stateCode, 0);
    maintMode = 1'b1;
    joinReq = 1'b1;
    cyc(4);
    chk("R8", "maintenance waits", stateCode, 0);
    pcmActive = 1'b1;
    cyc(1);
    chk("R8", "maintenance starts", stateCode, 1);
  endtask

  initial begin
    t_reset();
    t_insert();
    t_remove();
    t_rescrub();
    t_scrubInserted();
    t_sampleT();
    t_singleAttach();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule